// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block owns the chip-select lines of an SPI master. While idle it holds the select lines at a programmable idle pattern, which is meant to deselect every slave. A transfer is requested with a one-cycle start request. The request carries a six-bit select pattern and an eight-bit setup-delay field.

When the block accepts a request, it drives the supplied pattern onto the lines. It then waits the setup time, which is the field value plus two clock cycles. After that wait it fires a one-cycle start pulse to an external shift engine. When the engine returns a one-cycle completion pulse, the lines return to the idle pattern.

The pattern reaches the pins unchanged, bit for bit. One-wire-per-slave selection, binary-encoded slave addresses and mixtures of the two therefore all work with no mode setting.

Top module: `csseq_top`

## Requirements
- R1: A synchronous reset gives selOut = 6'b111111, busy = 0 and engineStart = 0 from the first cycle after the reset edge.
- R2: While idle, selOut equals the idle-pattern register. A write (idleWr high with idleIn) is visible on selOut from the next cycle.
- R3: A start request accepted while idle makes busy high and selOut equal to the captured selPattern from the next cycle. Any bit combination is allowed, including all zeros and several active bits.
- R4: engineStart goes high exactly setupDelay + 2 cycles after the cycle in which selOut first shows the transfer pattern.
- R5: The setup field is eight bits wide, so the setup time spans 2 to 257 cycles. Both extremes, field 0 and field 255, are honoured.
- R6: engineDone sampled high after the start pulse ends the transfer. From the next cycle selOut shows the idle pattern and busy is low.
- R7: A start request while busy is ignored. The pattern on the pins and the timing of the start pulse are unchanged.
- R8: selPattern and setupDelay are captured when a request is accepted. Later changes to these inputs have no effect on that transfer.
- R9: engineDone is ignored while idle and during the setup wait. It neither ends the transfer nor changes selOut.
- R10: An idle-pattern write during a transfer leaves selOut at the transfer pattern. The new idle value is the one restored at the end of the transfer.
- R11: engineStart is high for exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idleWr | input | 1 | Write strobe for the idle-pattern register |
| idleIn | input | 6 | New idle pattern |
| startReq | input | 1 | Transfer request, one cycle |
| selPattern | input | 6 | Chip-select pattern for the requested transfer |
| setupDelay | input | 8 | Setup field; the wait is the value plus 2 cycles |
| engineDone | input | 1 | Completion pulse from the shift engine |
| selOut | output | 6 | Chip-select pins |
| engineStart | output | 1 | One-cycle start pulse to the shift engine |
| busy | output | 1 | High from acceptance until the idle pattern is back |

## Verification
Transfers are run with the following combinations of idle pattern, select pattern and setup field:
- An all-ones idle pattern against single-bit and multi-bit active-low selects, which tells one-wire and encoded use apart.
- An all-zeros idle pattern, which shows that no polarity is assumed.
- A mixed idle pattern.
- Setup fields of 0, 1, small values and 255, which separate an off-by-one in the count from a truncated counter at the top of the range.

One disturbed transfer injects an early completion, a second request and an idle-pattern write during the setup wait. The bench then shows that the pins and the start timing are unaffected and that the new idle value is the one restored.

// File: rtl/csseq_pkg.sv
package csseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic active;
  } seqStrobes_t;

endpackage

// File: rtl/csseq_ctrl.sv
module csseq_ctrl
  import csseq_pkg::*;
#(
  parameter int DelayW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [DelayW-1:0] setupDelay,
  input  logic              engineDone,
  output seqStrobes_t       strb,
  output logic              busy,
  output logic              engineStart
);
  localparam int CntW = DelayW + 1;

  seqState_t state;
  logic [CntW-1:0] cnt;
  logic accept;

  assign accept = (state == ST_IDLE) && startReq;
  assign busy = (state != ST_IDLE);
  assign strb.capture = accept;
  assign strb.active = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt <= '0;
      engineStart <= 1'b0;
    end else begin
      engineStart <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cnt <= {1'b0, setupDelay} + CntW'(1);
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            engineStart <= 1'b1;
            state <= ST_RUN;
          end else begin
            cnt <= cnt - CntW'(1);
          end
        end
        ST_RUN: begin
          if (engineDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csseq_dpath.sv
module csseq_dpath
  import csseq_pkg::*;
#(
  parameter int SelW = 6,
  parameter logic [SelW-1:0] IdleReset = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  seqStrobes_t     strb,
  input  logic            idleWr,
  input  logic [SelW-1:0] idleIn,
  input  logic [SelW-1:0] selPattern,
  output logic [SelW-1:0] selOut
);
  logic [SelW-1:0] idleReg;
  logic [SelW-1:0] xferReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      idleReg <= IdleReset;
      xferReg <= IdleReset;
    end else begin
      if (idleWr) idleReg <= idleIn;
      if (strb.capture) xferReg <= selPattern;
    end
  end

  assign selOut = strb.active ? xferReg : idleReg;
endmodule

// File: rtl/csseq_top.sv
module csseq_top
  import csseq_pkg::*;
#(
  parameter int SelW = 6,
  parameter int DelayW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idleWr,
  input  logic [SelW-1:0]   idleIn,
  input  logic              startReq,
  input  logic [SelW-1:0]   selPattern,
  input  logic [DelayW-1:0] setupDelay,
  input  logic              engineDone,
  output logic [SelW-1:0]   selOut,
  output logic              engineStart,
  output logic              busy
);
  seqStrobes_t strb;

  csseq_ctrl #(.DelayW(DelayW)) u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .setupDelay(setupDelay),
    .engineDone(engineDone), .strb(strb), .busy(busy), .engineStart(engineStart)
  );

  csseq_dpath #(.SelW(SelW), .IdleReset({SelW{1'b1}})) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .idleWr(idleWr), .idleIn(idleIn),
    .selPattern(selPattern), .selOut(selOut)
  );
endmodule

// File: rtl/csseq_chk.sv
module csseq_chk #(
  parameter int SelW = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            startReq,
  input logic            engineDone,
  input logic            engineStart,
  input logic            busy,
  input logic [SelW-1:0] selOut
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !engineStart && selOut == {SelW{1'b1}}));

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && startReq) |=> busy);

  // R7
  pattern_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !engineDone) |=> $stable(selOut));

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    engineStart |=> !engineStart);

  // R4
  pulse_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    engineStart |-> busy);

  // R9
  idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !startReq) |=> (!busy && !engineStart));
endmodule

bind csseq_top csseq_chk #(.SelW(SelW)) u_chk (
  .clk(clk), .rst(rst), .startReq(startReq), .engineDone(engineDone),
  .engineStart(engineStart), .busy(busy), .selOut(selOut)
);

// File: tb/csseq_top_tb.sv
module csseq_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idleWr = 1'b0;
  logic [5:0] idleIn = '0;
  logic startReq = 1'b0;
  logic [5:0] selPattern = '0;
  logic [7:0] setupDelay = '0;
  logic engineDone = 1'b0;
  logic [5:0] selOut;
  logic engineStart;
  logic busy;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  csseq_top u_dut (
    .clk(clk), .rst(rst), .idleWr(idleWr), .idleIn(idleIn),
    .startReq(startReq), .selPattern(selPattern), .setupDelay(setupDelay),
    .engineDone(engineDone), .selOut(selOut), .engineStart(engineStart),
    .busy(busy)
  );

  // idle pattern, select pattern, setup field
  localparam logic [19:0] Vecs [7] = '{
    {6'h3F, 6'h3E, 8'd0},
    {6'h3F, 6'h15, 8'd3},
    {6'h00, 6'h2A, 8'd7},
    {6'h3C, 6'h31, 8'd1},
    {6'h3F, 6'h00, 8'd255},
    {6'h2D, 6'h3F, 8'd12},
    {6'h00, 6'h01, 8'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeIdle(input logic [5:0] v);
    idleIn = v;
    idleWr = 1'b1;
    @(negedge clk);
    idleWr = 1'b0;
  endtask

  task automatic doXfer(input logic [5:0] pat, input logic [7:0] dly,
                        input logic [5:0] expIdle, input bit disturb);
    int cnt;
    bit held;
    startReq = 1'b1;
    selPattern = pat;
    setupDelay = dly;
    @(negedge clk);
    startReq = 1'b0;
    selPattern = ~pat;       // R8 later input changes
    setupDelay = dly ^ 8'h5A;
    check(selOut == pat, "R3 pattern", selOut, pat);
    check(busy == 1'b1, "R3 busy", busy, 1);
    cnt = 0;
    held = 1'b1;
    while (!engineStart && cnt < 400) begin
      @(negedge clk);
      engineDone = 1'b0;
      startReq = 1'b0;
      idleWr = 1'b0;
      cnt++;
      if (!engineStart && selOut != pat) held = 1'b0;
      if (disturb && cnt == 1) engineDone = 1'b1;          // R9
      if (disturb && cnt == 2) begin                       // R7
        startReq = 1'b1;
        selPattern = pat ^ 6'h3F;
        setupDelay = 8'd0;
      end
      if (disturb && cnt == 3) begin                       // R10
        idleIn = expIdle;
        idleWr = 1'b1;
      end
    end
    check(cnt == int'(dly) + 2, "R4 R5 setup count", cnt, int'(dly) + 2);
    check(held, "R7 R8 R10 pins held", held, 1);
    check(selOut == pat, "R10 pins at pulse", selOut, pat);
    @(negedge clk);
    check(engineStart == 1'b0, "R11 pulse width", engineStart, 0);
    engineDone = 1'b1;
    @(negedge clk);
    engineDone = 1'b0;
    check(selOut == expIdle, "R6 restore", selOut, expIdle);
    check(busy == 1'b0, "R6 busy low", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(selOut == 6'h3F, "R1 selOut", selOut, 6'h3F);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(engineStart == 1'b0, "R1 engineStart", engineStart, 0);

    // R2 idle write
    writeIdle(6'h12);
    check(selOut == 6'h12, "R2 idle write", selOut, 6'h12);

    // R9 done while idle
    engineDone = 1'b1;
    @(negedge clk);
    engineDone = 1'b0;
    check(busy == 1'b0 && selOut == 6'h12, "R9 idle done", selOut, 6'h12);

    foreach (Vecs[i]) begin
      writeIdle(Vecs[i][19:14]);
      check(selOut == Vecs[i][19:14], "R2 idle shown", selOut, Vecs[i][19:14]);
      doXfer(Vecs[i][13:8], Vecs[i][7:0], Vecs[i][19:14], 1'b0);
    end

    // Disturbed transfer: R7, R8, R9, R10
    writeIdle(6'h3F);
    doXfer(6'h05, 8'd6, 6'h0F, 1'b1);
    check(engineStart == 1'b0 && busy == 1'b0, "R7 no second transfer", busy, 0);

    // Back-to-back restart
    doXfer(6'h20, 8'd1, 6'h0F, 1'b0);

    // R1 reset mid transfer
    startReq = 1'b1;
    selPattern = 6'h00;
    setupDelay = 8'd9;
    @(negedge clk);
    startReq = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(selOut == 6'h3F && busy == 1'b0, "R1 reset mid transfer", selOut, 6'h3F);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule